// File: doc/BRIEF.md
# BCD Alarm Time Setter

This block keeps an alarm time as four binary-coded decimal digits: tens and units of the hour, tens and units of the minute. A user sets it with three buttons. The set button steps a small mode machine from idle, to hour editing, to minute editing, and back to idle. While a field is being edited, the increment and decrement buttons step that field up or down by one and wrap at its limits.

The stored digits stay in decimal form the whole time. Because of this they can be compared one digit at a time against a current time that also arrives as BCD, with no divider or modulo stage in between. When the alarm is enabled and all four digits match, the buzzer output goes high in the same cycle.

The button inputs must already be clean levels that are synchronous to the clock. The block samples each button as data and reacts only to its rising edge, so holding a button down counts as one press.

Top module: `alarm_bcd_setter`

## Requirements
- R1: A synchronous active-low reset sets the stored time to 00:00 and the mode to idle. While the reset is active, the buttons have no effect.
- R2: Each rising edge on the set button moves the mode one step: idle, then hour editing, then minute editing, then back to idle.
- R3: In hour editing, an increment press adds one hour and goes from 23 to 00. A decrement press subtracts one hour and goes from 00 to 23.
- R4: In minute editing, an increment press adds one minute and goes from 59 to 00. A decrement press subtracts one minute and goes from 00 to 59.
- R5: The counting is in BCD. Incrementing when the units digit is 9 sets units to 0 and adds one to tens (19 to 20, 49 to 50). Decrementing when units is 0 sets units to 9 and subtracts one from tens (20 to 19, 50 to 49). Each digit stays in the range 0 to 9, on bits [3:0] of its port.
- R6: In idle mode, increment and decrement presses leave all four stored digits unchanged.
- R7: If increment and decrement have their rising edges in the same cycle, the stored time does not change.
- R8: Buttons are edge-detected. A button held high for many cycles counts as one press, and the stored time changes in the clock cycle where the rising edge is sampled.
- R9: The buzzer is high exactly when the alarm enable is high and all four stored digits equal the four current-time digits. It follows these inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alarm_en | input | 1 | Alarm enable |
| btn_set | input | 1 | Mode step button, clean level |
| btn_inc | input | 1 | Increment button, clean level |
| btn_dec | input | 1 | Decrement button, clean level |
| cur_hr_tens | input | 4 | Current time, hour tens, BCD |
| cur_hr_units | input | 4 | Current time, hour units, BCD |
| cur_min_tens | input | 4 | Current time, minute tens, BCD |
| cur_min_units | input | 4 | Current time, minute units, BCD |
| alm_hr_tens | output | 4 | Stored alarm, hour tens, BCD |
| alm_hr_units | output | 4 | Stored alarm, hour units, BCD |
| alm_min_tens | output | 4 | Stored alarm, minute tens, BCD |
| alm_min_units | output | 4 | Stored alarm, minute units, BCD |
| buzzer | output | 1 | High when enabled and the times match |

## Verification
The hardest cases to reach from the ports are the BCD borrow and carry across a tens boundary, such as 50 to 49 in the minute field. Starting from 00:00, reaching them takes a long chain of presses, and the mode must be right before each chain starts. The stimulus table walks the hour field down through the wrap from 00 to 23 and on to 19. It then walks the minute field down through 59 and ten more steps to 49, and checks the stored digits after every press. Directed tests follow the table. They hold set and increment high for several cycles to show a held button counts once, press both step buttons together, and compare each digit separately for the buzzer.

// File: rtl/alarm_pkg.sv
// Package: types and constants shared by the alarm setter modules.
// Assumes BCD digits are four bits wide.
package alarm_pkg;
    localparam int DIGIT_W = 4;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_HOUR = 2'd1,
        MODE_MIN  = 2'd2
    } edit_mode_e;
endpackage

// File: rtl/rise_detect.sv
// Rising-edge detector for a group of clean, synchronous button levels.
// Assumes inputs are already debounced and synchronous to clk.
module rise_detect #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] prev_q;

    // Purpose: remember last cycle's level of each button.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;

    // R8: one rise cannot be followed by another rise on the same line next cycle
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/mode_seq.sv
// Edit mode sequencer: idle -> hour -> minute -> idle on each set press.
// Assumes set_rise is a single-cycle pulse.
module mode_seq
    import alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_rise,
    output edit_mode_e mode
);
    edit_mode_e mode_q;

    // Purpose: advance the mode on each set press.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_IDLE;
        end else if (set_rise) begin
            unique case (mode_q)
                MODE_IDLE: mode_q <= MODE_HOUR;
                MODE_HOUR: mode_q <= MODE_MIN;
                default:   mode_q <= MODE_IDLE;
            endcase
        end
    end

    assign mode = mode_q;

    // R2: the step order is fixed
    p_idle_to_hour_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_IDLE && set_rise) |=> (mode_q == MODE_HOUR));
    p_hour_to_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_HOUR && set_rise) |=> (mode_q == MODE_MIN));
    p_min_to_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_MIN && set_rise) |=> (mode_q == MODE_IDLE));
    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !set_rise |=> $stable(mode_q));
endmodule

// File: rtl/bcd_wrap_ctr.sv
// Two-digit BCD up/down counter that wraps between 0 and MAX_VAL.
// Assumes inc and dec are never high together (the caller masks that case)
// and that MAX_VAL is between 10 and 99.
module bcd_wrap_ctr
    import alarm_pkg::*;
#(
    parameter int MAX_VAL = 59
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc,
    input  logic               dec,
    output logic [DIGIT_W-1:0] tens,
    output logic [DIGIT_W-1:0] units
);
    localparam logic [DIGIT_W-1:0] MAX_T = DIGIT_W'(MAX_VAL / 10);
    localparam logic [DIGIT_W-1:0] MAX_U = DIGIT_W'(MAX_VAL % 10);
    localparam logic [DIGIT_W-1:0] NINE  = DIGIT_W'(9);

    logic [DIGIT_W-1:0] tens_q, units_q;
    logic               at_max, at_zero;

    assign at_max  = (tens_q == MAX_T) && (units_q == MAX_U);
    assign at_zero = (tens_q == '0) && (units_q == '0);

    // Purpose: step the two BCD digits with decimal carry, borrow and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tens_q  <= '0;
            units_q <= '0;
        end else if (inc) begin
            if (at_max) begin
                tens_q  <= '0;
                units_q <= '0;
            end else if (units_q == NINE) begin
                tens_q  <= tens_q + 1'b1;
                units_q <= '0;
            end else begin
                units_q <= units_q + 1'b1;
            end
        end else if (dec) begin
            if (at_zero) begin
                tens_q  <= MAX_T;
                units_q <= MAX_U;
            end else if (units_q == '0) begin
                tens_q  <= tens_q - 1'b1;
                units_q <= NINE;
            end else begin
                units_q <= units_q - 1'b1;
            end
        end
    end

    assign tens  = tens_q;
    assign units = units_q;

    // R3 and R4: wrap both ways
    p_wrap_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && at_max) |=> (tens_q == '0 && units_q == '0));
    p_wrap_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && at_zero) |=> (tens_q == MAX_T && units_q == MAX_U));
    // R5: digits stay legal BCD, and the carry clears the units digit
    p_legal_bcd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (units_q <= NINE) && ({tens_q, units_q} <= {MAX_T, MAX_U}));
    p_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !at_max && units_q == NINE) |=> (units_q == '0 && tens_q == $past(tens_q) + 1'b1));
    p_borrow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && !at_zero && units_q == '0) |=> (units_q == NINE && tens_q == $past(tens_q) - 1'b1));
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !dec) |=> ($stable(tens_q) && $stable(units_q)));
endmodule

// File: rtl/time_match.sv
// Digit-wise equality of stored and current BCD time, gated by enable.
// Assumes both times are in the same digit order.
module time_match
    import alarm_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic                            enable,
    input  logic [DIGITS-1:0][DIGIT_W-1:0]  stored,
    input  logic [DIGITS-1:0][DIGIT_W-1:0]  current,
    output logic                            hit
);
    logic [DIGITS-1:0] eq;

    // Purpose: one comparator per digit.
    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        assign eq[d] = (stored[d] == current[d]);
    end

    assign hit = enable && (&eq);

    // R9: no hit without the enable
    always_comb begin
        if (!enable) p_no_hit_disabled_r9: assert (!hit);
    end
endmodule

// File: rtl/alarm_bcd_setter.sv
// Alarm time setter: holds HH:MM in BCD, edits it with buttons, and raises
// a buzzer on a match with the current BCD time.
// Assumes clean, synchronous button levels and a BCD current time.
module alarm_bcd_setter
    import alarm_pkg::*;
#(
    parameter int HOUR_MAX = 23,
    parameter int MIN_MAX  = 59
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         alarm_en,
    input  logic         btn_set,
    input  logic         btn_inc,
    input  logic         btn_dec,
    input  logic [3:0]   cur_hr_tens,
    input  logic [3:0]   cur_hr_units,
    input  logic [3:0]   cur_min_tens,
    input  logic [3:0]   cur_min_units,
    output logic [3:0]   alm_hr_tens,
    output logic [3:0]   alm_hr_units,
    output logic [3:0]   alm_min_tens,
    output logic [3:0]   alm_min_units,
    output logic         buzzer
);
    localparam int FIELDS = 2;
    localparam int DIGITS = 2 * FIELDS;

    logic [2:0]               rise;
    logic                     set_r, inc_r, dec_r, step_ok;
    edit_mode_e               mode;
    logic [FIELDS-1:0]        fld_inc, fld_dec;
    logic [FIELDS-1:0][DIGIT_W-1:0] f_tens, f_units;
    logic [DIGITS-1:0][DIGIT_W-1:0] stored_t, current_t;

    rise_detect #(.WIDTH(3)) u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level ({btn_dec, btn_inc, btn_set}),
        .rise  (rise)
    );
    assign set_r = rise[0];
    assign inc_r = rise[1];
    assign dec_r = rise[2];

    mode_seq u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_rise (set_r),
        .mode     (mode)
    );

    // R7: a simultaneous increment and decrement is dropped
    assign step_ok = inc_r ^ dec_r;

    // Purpose: one wrapping BCD counter per field; field 0 hours, field 1 minutes.
    for (genvar f = 0; f < FIELDS; f++) begin : g_field
        localparam int         LIMIT = (f == 0) ? HOUR_MAX : MIN_MAX;
        localparam edit_mode_e OWNER = (f == 0) ? MODE_HOUR : MODE_MIN;

        assign fld_inc[f] = step_ok && inc_r && (mode == OWNER);
        assign fld_dec[f] = step_ok && dec_r && (mode == OWNER);

        bcd_wrap_ctr #(.MAX_VAL(LIMIT)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (fld_inc[f]),
            .dec   (fld_dec[f]),
            .tens  (f_tens[f]),
            .units (f_units[f])
        );
    end

    assign alm_hr_tens   = f_tens[0];
    assign alm_hr_units  = f_units[0];
    assign alm_min_tens  = f_tens[1];
    assign alm_min_units = f_units[1];

    assign stored_t  = {alm_hr_tens, alm_hr_units, alm_min_tens, alm_min_units};
    assign current_t = {cur_hr_tens, cur_hr_units, cur_min_tens, cur_min_units};

    time_match #(.DIGITS(DIGITS)) u_match (
        .enable  (alarm_en),
        .stored  (stored_t),
        .current (current_t),
        .hit     (buzzer)
    );

    // R6: idle mode freezes the stored time
    p_idle_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IDLE) |=> $stable(stored_t));
    // R7: both step presses together change nothing
    p_both_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_r && dec_r) |=> $stable(stored_t));
    // R1: after a reset cycle the time reads 00:00
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (stored_t == '0));
endmodule

// File: tb/alarm_bcd_setter_bench.sv
`timescale 1ns/1ps
module alarm_bcd_setter_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alarm_en = 1'b0;
    logic btn_set = 1'b0, btn_inc = 1'b0, btn_dec = 1'b0;
    logic [3:0] cur_hr_tens = '0, cur_hr_units = '0, cur_min_tens = '0, cur_min_units = '0;
    logic [3:0] alm_hr_tens, alm_hr_units, alm_min_tens, alm_min_units;
    logic buzzer;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    alarm_bcd_setter u_alarm_bcd_setter (
        .clk(clk), .rst_n(rst_n), .alarm_en(alarm_en),
        .btn_set(btn_set), .btn_inc(btn_inc), .btn_dec(btn_dec),
        .cur_hr_tens(cur_hr_tens), .cur_hr_units(cur_hr_units),
        .cur_min_tens(cur_min_tens), .cur_min_units(cur_min_units),
        .alm_hr_tens(alm_hr_tens), .alm_hr_units(alm_hr_units),
        .alm_min_tens(alm_min_tens), .alm_min_units(alm_min_units),
        .buzzer(buzzer)
    );

    // Op codes: 0 set, 1 inc, 2 dec, 3 inc and dec together.
    // Entry: {op, expected HHMM as BCD}.
    localparam int NVEC = 32;
    localparam logic [17:0] VEC [NVEC] = '{
        {2'd1, 16'h0000}, {2'd2, 16'h0000}, {2'd0, 16'h0000}, {2'd2, 16'h2300},
        {2'd1, 16'h0000}, {2'd2, 16'h2300}, {2'd2, 16'h2200}, {2'd2, 16'h2100},
        {2'd2, 16'h2000}, {2'd2, 16'h1900}, {2'd1, 16'h2000}, {2'd2, 16'h1900},
        {2'd3, 16'h1900}, {2'd0, 16'h1900}, {2'd2, 16'h1959}, {2'd1, 16'h1900},
        {2'd2, 16'h1959}, {2'd2, 16'h1958}, {2'd2, 16'h1957}, {2'd2, 16'h1956},
        {2'd2, 16'h1955}, {2'd2, 16'h1954}, {2'd2, 16'h1953}, {2'd2, 16'h1952},
        {2'd2, 16'h1951}, {2'd2, 16'h1950}, {2'd2, 16'h1949}, {2'd1, 16'h1950},
        {2'd3, 16'h1950}, {2'd0, 16'h1950}, {2'd1, 16'h1950}, {2'd2, 16'h1950}
    };

    function automatic string vec_tag(int i);
        if (i <= 1 || i >= 30)                 return "R6";
        if (i == 2 || i == 13 || i == 29)      return "R2";
        if (i == 12 || i == 28)                return "R7";
        if ((i >= 8 && i <= 11) || i >= 25)    return "R5";
        if (i >= 3 && i <= 7)                  return "R3";
        return "R4";
    endfunction

    function automatic logic [15:0] shown();
        return {alm_hr_tens, alm_hr_units, alm_min_tens, alm_min_units};
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Press: raise at a falling edge, lower at the next, settle one more.
    task automatic press(logic [1:0] op);
        @(negedge clk);
        btn_set = (op == 2'd0);
        btn_inc = (op == 2'd1 || op == 2'd3);
        btn_dec = (op == 2'd2 || op == 2'd3);
        @(negedge clk);
        btn_set = 1'b0; btn_inc = 1'b0; btn_dec = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_cur(logic [15:0] t);
        {cur_hr_tens, cur_hr_units, cur_min_tens, cur_min_units} = t;
        #0.1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset value", shown(), 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            press(VEC[i][17:16]);
            check(vec_tag(i), shown(), VEC[i][15:0]);
        end

        // R9: buzzer on an exact enabled match at 19:50
        alarm_en = 1'b1;
        set_cur(16'h1950);
        check("R9 match enabled", {15'd0, buzzer}, 16'd1);
        alarm_en = 1'b0; #0.1;
        check("R9 match disabled", {15'd0, buzzer}, 16'd0);
        alarm_en = 1'b1;
        for (int d = 0; d < 4; d++) begin
            set_cur(16'h1950 ^ (16'h1 << (4 * d)));
            check("R9 one digit differs", {15'd0, buzzer}, 16'd0);
        end
        set_cur(16'h0000);

        // R8: held set goes idle -> hour only once; held inc steps once
        @(negedge clk); btn_set = 1'b1;
        repeat (6) @(negedge clk); btn_set = 1'b0;
        @(negedge clk); btn_inc = 1'b1;
        repeat (6) @(negedge clk);
        check("R8 held inc in hour mode", shown(), 16'h2050);
        btn_inc = 1'b0;
        @(negedge clk);

        // R1: reset mid-edit clears time and mode
        rst_n = 1'b0;
        btn_inc = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 reset during press", shown(), 16'h0000);
        btn_inc = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        press(2'd1);
        check("R1 idle after reset", shown(), 16'h0000);
        // R2: one set press after reset selects hours
        press(2'd0);
        press(2'd1);
        check("R2 hour mode after one set", shown(), 16'h0100);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule